// File: doc/BRIEF.md
# Bus Cycle Timeout Responder

This block watches an asynchronous, strobe-framed processor bus and rescues bus cycles that nothing on the bus answers. A bus cycle starts when the active-low address strobe falls. It ends normally when some device pulls the shared data acknowledge low. If no device does this before a chosen interval has passed, the block ends the cycle itself. It does so in one of two ways, set by a mode input:

- It fakes a data acknowledge, so the processor completes the cycle and reads whatever is floating on the bus.
- It raises a bus error, so the processor takes its fault path.

A cycle counter measures the interval. The counter is held at zero while the strobe is high and counts clock edges while the strobe is low. One counter bit is chosen as the trigger: bit 7 plus the 3-bit tap select, which covers bits 7 through 14. A lower bit gives a shorter wait. Bit 7 is short enough to cut off slow devices that would have answered, so after reset the block uses tap code 3 (bit 10) and acknowledge mode until the configuration inputs are next sampled.

All inputs are synchronous to `clk`. Both outputs are active low and meant for open-drain use. They are only ever driven low to assert, and they read high when released.

Top module: `bus_timeout_responder`

## Requirements
- R1: While `as_n` is high the counter is held at zero. Counting starts at the first rising clock edge at which `as_n` is sampled low; that edge is edge 0 of the cycle.
- R2: With tap code S (bit B = 7 + S, T = 2^B), if no acknowledge is seen the selected output goes low just after edge T of the cycle.
- R3: With `mode_sel` = 0, a timeout drives `force_dtack_n` low and leaves `berr_n` high.
- R4: With `mode_sel` = 1, a timeout drives `berr_n` low and leaves `force_dtack_n` high.
- R5: If `sys_dtack_n` is sampled low at any edge k ≤ T of a cycle, neither output goes low for the rest of that cycle. An acknowledge sampled after edge T does not change an output that has already asserted.
- R6: Once an output has asserted, it stays low for as long as `as_n` stays low. It goes high just after the first edge at which `as_n` is sampled high.
- R7: Each bus cycle produces at most one assertion, even when the strobe is held low long enough for the trigger bit to toggle again.
- R8: `tap_sel` and `mode_sel` are captured only at edges where `as_n` is high. Changes to them while `as_n` is low have no effect on the current cycle.
- R9: Synchronous reset releases both outputs and clears the counter. It also loads tap code 3 and acknowledge mode, and the block uses these for a cycle that begins straight out of reset, without any idle edge in between.
- R10: `force_dtack_n` and `berr_n` are never both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| as_n | input | 1 | Address strobe, active low; low frames a bus cycle |
| sys_dtack_n | input | 1 | Acknowledge from the rest of the system, active low |
| mode_sel | input | 1 | 0: end a timed-out cycle with a forced acknowledge; 1: with a bus error |
| tap_sel | input | 3 | Trigger bit select; counter bit 7 + tap_sel |
| force_dtack_n | output | 1 | Forced data acknowledge, active low |
| berr_n | output | 1 | Bus error, active low |

## Verification
The counter, the captured configuration and the response state are all registered. An output therefore changes just after edge T of a cycle (R2), and it releases just after the first edge with the strobe high (R6). An acknowledge counts if it is sampled at an edge no later than edge T.

The bench drives every input at the falling clock edge. A behavioural reference model, made of integer counts and flags, is updated at each rising edge. Both outputs are compared with this model at each falling edge, which is half a period after the edge that should have changed them.

For each directed cycle, the bench also records the index of the first edge after which an output was low. It compares that index and the number of assertions with the value 2^(7+S) worked out from the requirements. Its acknowledge cases fall just before, exactly on, and just after edge T.

// File: rtl/bto_pkg.sv
package bto_pkg;

    localparam int TAP_BASE_DEF  = 7;
    localparam int TAP_SEL_W_DEF = 3;
    localparam int RESET_TAP_DEF = 3;

    typedef enum logic {
        RESP_ACK  = 1'b0,
        RESP_BERR = 1'b1
    } resp_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ARMED    = 2'd1,
        ST_FIRED    = 2'd2,
        ST_ANSWERED = 2'd3
    } resp_state_e;

    function automatic int cnt_width(input int tap_base, input int sel_w);
        return tap_base + (1 << sel_w);
    endfunction

endpackage

// File: rtl/bto_cfg_latch.sv
module bto_cfg_latch
    import bto_pkg::*;
#(
    parameter int TAP_SEL_W = TAP_SEL_W_DEF,
    parameter int RESET_TAP = RESET_TAP_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 as_n,
    input  logic [TAP_SEL_W-1:0] tap_in,
    input  logic                 mode_in,
    output logic [TAP_SEL_W-1:0] tap_q,
    output resp_mode_e           mode_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_q  <= TAP_SEL_W'(RESET_TAP);
            mode_q <= RESP_ACK;
        end else if (as_n) begin
            tap_q  <= tap_in;
            mode_q <= resp_mode_e'(mode_in);
        end
    end

    // R8: configuration frozen while a cycle is open
    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        !as_n |=> ($stable(tap_q) && $stable(mode_q)));

endmodule

// File: rtl/bto_cycle_counter.sv
module bto_cycle_counter
    import bto_pkg::*;
#(
    parameter int CNT_W = cnt_width(TAP_BASE_DEF, TAP_SEL_W_DEF)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             as_n,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || as_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R1: counter cleared while strobe is idle
    a_r1_cnt_cleared: assert property (@(posedge clk) disable iff (rst)
        as_n |=> (cnt == '0));

endmodule

// File: rtl/bto_fire_ctrl.sv
module bto_fire_ctrl
    import bto_pkg::*;
#(
    parameter int TAP_BASE  = TAP_BASE_DEF,
    parameter int TAP_SEL_W = TAP_SEL_W_DEF,
    parameter int CNT_W     = cnt_width(TAP_BASE_DEF, TAP_SEL_W_DEF)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 as_n,
    input  logic                 sys_dtack_n,
    input  logic [CNT_W-1:0]     cnt,
    input  logic [TAP_SEL_W-1:0] tap_q,
    input  resp_mode_e           mode_q,
    output logic                 force_dtack_n,
    output logic                 berr_n
);

    localparam int IDX_W = $clog2(CNT_W);

    resp_state_e      state;
    logic [IDX_W-1:0] tap_idx;
    logic             tap_hit;
    logic             sys_ack;

    assign tap_idx = IDX_W'(TAP_BASE) + IDX_W'(tap_q);
    assign tap_hit = cnt[tap_idx];
    assign sys_ack = !sys_dtack_n;

    always_ff @(posedge clk) begin
        if (rst || as_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_ARMED: begin
                    if (sys_ack)      state <= ST_ANSWERED;
                    else if (tap_hit) state <= ST_FIRED;
                    else              state <= ST_ARMED;
                end
                default: state <= state;
            endcase
        end
    end

    assign force_dtack_n = !((state == ST_FIRED) && (mode_q == RESP_ACK));
    assign berr_n        = !((state == ST_FIRED) && (mode_q == RESP_BERR));

    // R5: an answer seen before any response keeps the cycle quiet
    a_r5_ack_blocks: assert property (@(posedge clk) disable iff (rst)
        (!as_n && !sys_dtack_n && force_dtack_n && berr_n) |=> (force_dtack_n && berr_n));

    // R6: held while the strobe stays low
    a_r6_hold_ack: assert property (@(posedge clk) disable iff (rst)
        (!as_n && !force_dtack_n) |=> !force_dtack_n);
    a_r6_hold_berr: assert property (@(posedge clk) disable iff (rst)
        (!as_n && !berr_n) |=> !berr_n);

endmodule

// File: rtl/bus_timeout_responder.sv
module bus_timeout_responder
    import bto_pkg::*;
#(
    parameter int TAP_BASE  = TAP_BASE_DEF,
    parameter int TAP_SEL_W = TAP_SEL_W_DEF,
    parameter int RESET_TAP = RESET_TAP_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 as_n,
    input  logic                 sys_dtack_n,
    input  logic                 mode_sel,
    input  logic [TAP_SEL_W-1:0] tap_sel,
    output logic                 force_dtack_n,
    output logic                 berr_n
);

    localparam int CNT_W = cnt_width(TAP_BASE, TAP_SEL_W);

    logic [TAP_SEL_W-1:0] tap_q;
    resp_mode_e           mode_q;
    logic [CNT_W-1:0]     cnt;

    bto_cfg_latch #(
        .TAP_SEL_W (TAP_SEL_W),
        .RESET_TAP (RESET_TAP)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .as_n    (as_n),
        .tap_in  (tap_sel),
        .mode_in (mode_sel),
        .tap_q   (tap_q),
        .mode_q  (mode_q)
    );

    bto_cycle_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .as_n (as_n),
        .cnt  (cnt)
    );

    bto_fire_ctrl #(
        .TAP_BASE  (TAP_BASE),
        .TAP_SEL_W (TAP_SEL_W),
        .CNT_W     (CNT_W)
    ) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .as_n          (as_n),
        .sys_dtack_n   (sys_dtack_n),
        .cnt           (cnt),
        .tap_q         (tap_q),
        .mode_q        (mode_q),
        .force_dtack_n (force_dtack_n),
        .berr_n        (berr_n)
    );

    // R6: release one edge after the strobe is seen high
    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        as_n |=> (force_dtack_n && berr_n));

    // R10: never both responses
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !force_dtack_n |-> berr_n);

endmodule

// File: tb/bus_timeout_responder_tb.sv
module bus_timeout_responder_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       as_n = 1'b1;
    logic       dtk_n = 1'b1;
    logic       mode_sel = 1'b0;
    logic [2:0] tap_sel = 3'd0;
    logic       force_dtack_n;
    logic       berr_n;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    bus_timeout_responder u_dut (
        .clk           (clk),
        .rst           (rst),
        .as_n          (as_n),
        .sys_dtack_n   (dtk_n),
        .mode_sel      (mode_sel),
        .tap_sel       (tap_sel),
        .force_dtack_n (force_dtack_n),
        .berr_n        (berr_n)
    );

    // behavioural reference model
    int m_n = 0;
    bit m_fired = 0, m_done = 0, m_mode = 0, m_valid = 0;
    int m_tap = 3;

    always @(posedge clk) begin
        m_valid = 1;
        if (rst || as_n) begin
            m_n = 0; m_fired = 0; m_done = 0;
            if (rst) begin m_tap = 3; m_mode = 0; end
            else begin m_tap = int'(tap_sel); m_mode = mode_sel; end
        end else begin
            if (!m_fired && !m_done) begin
                if (!dtk_n) m_done = 1;
                else if (m_n >= (1 << (7 + m_tap))) m_fired = 1;
            end
            m_n++;
        end
    end

    always @(negedge clk) begin
        if (m_valid) begin
            checks++;
            if (force_dtack_n !== !(m_fired && !m_mode) || berr_n !== !(m_fired && m_mode)) begin
                errors++;
                $display("FAIL %s model: actual dtack_n=%b berr_n=%b expected dtack_n=%b berr_n=%b",
                         cur_req, force_dtack_n, berr_n, !(m_fired && !m_mode), !(m_fired && m_mode));
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one bus cycle; ack_at < 0 means no system acknowledge
    task automatic run_cycle(input int sel, input bit md, input int ack_at,
                             input int hold, input bit chg, input string req);
        int first = -1;
        int which = -1;
        int n_assert = 0;
        bit prev = 0;
        int t = 1 << (7 + sel);
        bit fire = (hold > t) && (ack_at < 0 || ack_at > t);
        cur_req = req;
        tap_sel = 3'(sel); mode_sel = md; as_n = 1'b1; dtk_n = 1'b1;
        repeat (2) @(negedge clk);
        as_n = 1'b0;
        for (int k = 0; k < hold; k++) begin
            if (ack_at >= 0 && k >= ack_at) dtk_n = 1'b0;
            if (chg && k == 5) begin tap_sel = 3'd7; mode_sel = !md; end
            @(negedge clk);
            if (!force_dtack_n || !berr_n) begin
                if (!prev) n_assert++;
                if (first < 0) begin first = k; which = !berr_n ? 1 : 0; end
                prev = 1;
            end else prev = 0;
        end
        chk(first == (fire ? t : -1), {req, " first response edge"}, first, fire ? t : -1);
        chk(n_assert == (fire ? 1 : 0), {req, " R7 assertions per cycle"}, n_assert, fire ? 1 : 0);
        if (fire) chk(which == int'(md), {req, " R3/R4 output choice"}, which, int'(md));
        as_n = 1'b1; dtk_n = 1'b1;
        @(negedge clk);
        chk(force_dtack_n && berr_n, "R6 release after strobe high", {force_dtack_n, berr_n}, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(force_dtack_n && berr_n, "R9 reset outputs released", {force_dtack_n, berr_n}, 3);
        rst = 1'b0;
        run_cycle(0, 0, -1, 200, 0, "R2 R3 tap0 ack mode");
        run_cycle(0, 1, -1, 200, 0, "R4 tap0 berr mode");
        run_cycle(1, 0, -1, 300, 0, "R2 tap1");
        run_cycle(1, 1, 100, 300, 0, "R5 early ack");
        run_cycle(0, 0, 128, 200, 0, "R5 ack on edge T");
        run_cycle(0, 1, 129, 200, 0, "R5 ack after edge T");
        run_cycle(0, 0, -1, 600, 0, "R7 long strobe");
        run_cycle(0, 0, -1, 200, 1, "R8 mid-cycle config change");
        run_cycle(3, 1, -1, 1100, 0, "R2 tap3");
        run_cycle(7, 1, -1, 16400, 0, "R2 tap7 longest");
        run_cycle(0, 0, -1, 100, 0, "R1 short strobe");
        // R9: cycle starting straight out of reset uses tap 3, ack mode
        begin
            int first = -1;
            bit dt = 0;
            cur_req = "R9";
            tap_sel = 3'd0; mode_sel = 1'b1; as_n = 1'b0; rst = 1'b1;
            @(negedge clk);
            rst = 1'b0;
            for (int k = 0; k < 1100; k++) begin
                @(negedge clk);
                if (first < 0 && (!force_dtack_n || !berr_n)) begin
                    first = k; dt = !force_dtack_n;
                end
            end
            chk(first == 1024, "R9 default tap after reset", first, 1024);
            chk(dt, "R9 default mode after reset", int'(dt), 1);
            as_n = 1'b1;
            repeat (2) @(negedge clk);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule